// File: doc/BRIEF.md
# Two-Cycle Command/Address Sequencer

This block sits on the controller side of a low-power DRAM channel. It takes one high-level request at a time and turns it into a series of command slots on a 6-bit single-data-rate command/address bus. There are four request kinds: open a row, read, write and mode-register read. Every command takes two clock cycles. The chip-select output is high in the first cycle and low in the second. A request that moves data is sent as a pair of commands: the transfer command, followed at once by a second-half command that carries the low-order column bits.

The block keeps one open-row entry per bank. A read or write to a bank with no open row is sent with a row-open pair in front of it. A request the block cannot send legally is refused. This covers a misaligned column, a row conflict in an open bank, an open request to a bank that is already open, and a mode-register read with a nonzero column. A refused request gets an error response and puts nothing on the bus.

The requester uses a valid/ready handshake and gets a one-cycle response pulse. The opcode of each command is a parameter.

Top module: `ca_pair_sequencer`

## Requirements
- R1: After reset, req_ready is 1, mem_cs is 0, mem_ca is the idle value (default 6'b000000) and rsp_valid is 0.
- R2: Each command takes exactly two cycles: mem_cs is 1 in the first cycle and 0 in the second. mem_cs is never 1 in two consecutive cycles.
- R3: First cycle: CA[5:3] holds the opcode (defaults: open-1 = 1, open-2 = 2, read = 3, write = 4, mode-read = 5, second-half = 6). CA[2:0] holds the bank for open-1, read and write; row[8:6] for open-2; 0 for mode-read and second-half. Second cycle, CA[5:0]: row[14:9] for open-1; row[5:0] for open-2 and mode-read; col[9:4] for read and write; {col[3:2], 4'b0000} for second-half. Row and column are zero-extended to 15 and 10 bits.
- R4: A row-open request (kind 2'b00) to a closed bank sends open-1 then open-2 (4 cycles) and marks the bank open with that row. A row-open request to a bank that is already open is refused.
- R5: A read (kind 2'b01) or write (kind 2'b10) to a closed bank sends open-1, open-2, the transfer command and second-half (8 cycles), and opens the bank with the request row.
- R6: A read or write to an open bank with a matching row sends only the transfer command and second-half (4 cycles). A read or write to an open bank with a different row is refused.
- R7: A read whose column has col[1:0] != 0 is refused.
- R8: A write whose column has col[3:0] != 0 is refused. An accepted write therefore sends zero in CA[5:4] of the second cycle of its second-half command.
- R9: A mode-register read (kind 2'b11) sends mode-read then second-half, with an all-zero column. It leaves bank state unchanged. A mode-register read with a nonzero column is refused.
- R10: A refused request produces rsp_valid=1 with rsp_err=1 in the cycle after acceptance. It drives no command, leaves bank state unchanged, and req_ready stays 1.
- R11: An accepted request produces rsp_valid=1 with rsp_err=0 in the cycle after acceptance; that is the same cycle as the first command cycle. req_ready is 0 from then until the last command cycle. When no command is in progress, mem_cs is 0 and mem_ca is the idle value.
- R12: Every read, write or mode-read command is followed directly by a second-half command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can take a request |
| req_kind | input | 2 | 00 open row, 01 read, 10 write, 11 mode-register read |
| req_bank | input | BANK_W | Bank index |
| req_row | input | ROW_W | Row address, or register address for mode read |
| req_col | input | COL_W | Column address |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_err | output | 1 | Response is a refusal |
| mem_cs | output | 1 | Chip select, high on first command cycle |
| mem_ca | output | 6 | Command/address bus |

## Verification
The assertions assume the following about the inputs:
- req_valid is at a known level at every clock edge after reset.
- The request fields matter only in the cycle a request is accepted.
- No outside agent closes rows behind the sequencer's back, so the bank-state check relies only on the block's own updates.

The stimulus drives every input half a period away from the sampling edge. It holds req_valid for exactly one accepted cycle, and it picks each field value within its declared width. This lets the bench model the open-row state itself, in parallel with the design.

// File: rtl/ca_seq_pkg.sv
package ca_seq_pkg;
   localparam int CA_W      = 6;
   localparam int OPC_W     = 3;
   localparam int ROW_FLD_W = 15;
   localparam int COL_FLD_W = 10;
   localparam int BANK_FLD_W = 3;
   localparam int SLOTS     = 4;
   localparam int SLOT_W    = $clog2(SLOTS);

   typedef enum logic [1:0] {
      K_OPEN = 2'b00,
      K_RD   = 2'b01,
      K_WR   = 2'b10,
      K_MRD  = 2'b11
   } req_kind_e;

   typedef enum logic [2:0] {
      C_OPEN1 = 3'd0,
      C_OPEN2 = 3'd1,
      C_RD    = 3'd2,
      C_WR    = 3'd3,
      C_MRD   = 3'd4,
      C_HALF2 = 3'd5
   } cmd_e;

   typedef struct packed {
      logic [BANK_FLD_W-1:0] bank;
      logic [ROW_FLD_W-1:0]  row;
      logic [COL_FLD_W-1:0]  col;
   } fields_t;
endpackage

// File: rtl/ca_bank_table.sv
module ca_bank_table
   import ca_seq_pkg::*;
#(
   parameter int BANK_W = 3,
   parameter int ROW_W  = 15,
   localparam int NBANK = 1 << BANK_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] lk_bank,
   output logic              lk_open,
   output logic [ROW_W-1:0]  lk_row,
   input  logic              upd_en,
   input  logic [BANK_W-1:0] upd_bank,
   input  logic [ROW_W-1:0]  upd_row
);
   logic             open_q [NBANK];
   logic [ROW_W-1:0] row_q  [NBANK];

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            open_q[b] <= 1'b0;
            row_q[b]  <= '0;
         end else if (upd_en && (upd_bank == BANK_W'(b))) begin
            open_q[b] <= 1'b1;
            row_q[b]  <= upd_row;
         end
      end
   end

   assign lk_open = open_q[lk_bank];
   assign lk_row  = row_q[lk_bank];

   // R4: the sequencer never asks to open a bank that is already open
   p_no_reopen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |-> !open_q[upd_bank]);
endmodule

// File: rtl/ca_req_check.sv
module ca_req_check
   import ca_seq_pkg::*;
(
   input  req_kind_e               kind,
   input  logic [COL_FLD_W-1:0]    col,
   input  logic                    bank_open,
   input  logic                    row_hit,
   output logic                    err,
   output logic                    need_open,
   output logic                    sets_bank,
   output cmd_e [SLOTS-1:0]        cmds,
   output logic [SLOT_W-1:0]       last_slot
);
   localparam int RD_ALIGN = 2;
   localparam int WR_ALIGN = 4;

   logic rd_misaligned, wr_misaligned, col_nonzero;

   always_comb begin
      rd_misaligned = |col[RD_ALIGN-1:0];
      wr_misaligned = |col[WR_ALIGN-1:0];
      col_nonzero   = |col;
   end

   always_comb begin
      err       = 1'b0;
      need_open = 1'b0;
      sets_bank = 1'b0;
      last_slot = SLOT_W'(1);
      for (int i = 0; i < SLOTS; i++) cmds[i] = C_HALF2;
      unique case (kind)
         K_OPEN: begin
            err       = bank_open;
            sets_bank = !bank_open;
            cmds[0]   = C_OPEN1;
            cmds[1]   = C_OPEN2;
         end
         K_RD, K_WR: begin
            err = ((kind == K_RD) ? rd_misaligned : wr_misaligned)
                  || (bank_open && !row_hit);
            need_open = !bank_open;
            sets_bank = !err && !bank_open;
            if (!bank_open) begin
               cmds[0]   = C_OPEN1;
               cmds[1]   = C_OPEN2;
               cmds[2]   = (kind == K_RD) ? C_RD : C_WR;
               cmds[3]   = C_HALF2;
               last_slot = SLOT_W'(3);
            end else begin
               cmds[0] = (kind == K_RD) ? C_RD : C_WR;
               cmds[1] = C_HALF2;
            end
         end
         K_MRD: begin
            err     = col_nonzero;
            cmds[0] = C_MRD;
            cmds[1] = C_HALF2;
         end
         default: err = 1'b1;
      endcase
   end
endmodule

// File: rtl/ca_beat_gen.sv
module ca_beat_gen
   import ca_seq_pkg::*;
#(
   parameter logic [OPC_W-1:0] OP_OPEN1 = 3'd1,
   parameter logic [OPC_W-1:0] OP_OPEN2 = 3'd2,
   parameter logic [OPC_W-1:0] OP_RD    = 3'd3,
   parameter logic [OPC_W-1:0] OP_WR    = 3'd4,
   parameter logic [OPC_W-1:0] OP_MRD   = 3'd5,
   parameter logic [OPC_W-1:0] OP_HALF2 = 3'd6
)(
   input  cmd_e             cmd,
   input  logic             second,
   input  fields_t          f,
   output logic [CA_W-1:0]  ca
);
   localparam int PAY_W = CA_W - OPC_W;

   logic [OPC_W-1:0] opc;
   logic [PAY_W-1:0] pay0;
   logic [CA_W-1:0]  pay1;

   always_comb begin
      opc  = OP_HALF2;
      pay0 = '0;
      pay1 = '0;
      unique case (cmd)
         C_OPEN1: begin opc = OP_OPEN1; pay0 = f.bank;      pay1 = f.row[14:9]; end
         C_OPEN2: begin opc = OP_OPEN2; pay0 = f.row[8:6];  pay1 = f.row[5:0];  end
         C_RD:    begin opc = OP_RD;    pay0 = f.bank;      pay1 = f.col[9:4];  end
         C_WR:    begin opc = OP_WR;    pay0 = f.bank;      pay1 = f.col[9:4];  end
         C_MRD:   begin opc = OP_MRD;   pay0 = '0;          pay1 = f.row[5:0];  end
         C_HALF2: begin opc = OP_HALF2; pay0 = '0;          pay1 = {f.col[3:2], 4'b0000}; end
         default: begin opc = OP_HALF2; pay0 = '0;          pay1 = '0; end
      endcase
      ca = second ? pay1 : {opc, pay0};
   end
endmodule

// File: rtl/ca_pair_sequencer.sv
module ca_pair_sequencer
   import ca_seq_pkg::*;
#(
   parameter int BANK_W = 3,
   parameter int ROW_W  = 15,
   parameter int COL_W  = 10,
   parameter logic [2:0] OP_OPEN1 = 3'd1,
   parameter logic [2:0] OP_OPEN2 = 3'd2,
   parameter logic [2:0] OP_RD    = 3'd3,
   parameter logic [2:0] OP_WR    = 3'd4,
   parameter logic [2:0] OP_MRD   = 3'd5,
   parameter logic [2:0] OP_HALF2 = 3'd6,
   parameter logic [5:0] IDLE_CA  = 6'b000000
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [1:0]        req_kind,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [COL_W-1:0]  req_col,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic              mem_cs,
   output logic [5:0]        mem_ca
);
   // elaboration-time parameter checks
   if (BANK_W < 1 || BANK_W > BANK_FLD_W) begin : g_bad_bank
      $error("BANK_W out of range");
   end
   if (ROW_W < 9 || ROW_W > ROW_FLD_W) begin : g_bad_row
      $error("ROW_W out of range");
   end
   if (COL_W < 4 || COL_W > COL_FLD_W) begin : g_bad_col
      $error("COL_W out of range");
   end
   if (OP_HALF2 == OP_RD || OP_HALF2 == OP_WR || OP_HALF2 == OP_MRD ||
       OP_HALF2 == OP_OPEN1 || OP_HALF2 == OP_OPEN2 || OP_RD == OP_WR) begin : g_bad_op
      $error("opcode parameters collide");
   end

   fields_t             req_f;
   logic                accept;
   logic                tb_open;
   logic [ROW_W-1:0]    tb_row;
   logic                chk_err, chk_need_open, chk_sets;
   cmd_e [SLOTS-1:0]    chk_cmds;
   logic [SLOT_W-1:0]   chk_last;

   logic                busy_q, second_q, rsp_v_q, rsp_e_q;
   logic [SLOT_W-1:0]   slot_q, last_q;
   cmd_e [SLOTS-1:0]    cmds_q;
   fields_t             f_q;
   logic [CA_W-1:0]     beat_ca;

   always_comb begin
      req_f.bank = BANK_FLD_W'(req_bank);
      req_f.row  = ROW_FLD_W'(req_row);
      req_f.col  = COL_FLD_W'(req_col);
   end

   assign req_ready = !busy_q;
   assign accept    = req_valid && req_ready;

   ca_bank_table #(.BANK_W(BANK_W), .ROW_W(ROW_W)) u_banks (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_bank  (req_bank),
      .lk_open  (tb_open),
      .lk_row   (tb_row),
      .upd_en   (accept && chk_sets),
      .upd_bank (req_bank),
      .upd_row  (req_row)
   );

   ca_req_check u_check (
      .kind      (req_kind_e'(req_kind)),
      .col       (req_f.col),
      .bank_open (tb_open),
      .row_hit   (tb_row == req_row),
      .err       (chk_err),
      .need_open (chk_need_open),
      .sets_bank (chk_sets),
      .cmds      (chk_cmds),
      .last_slot (chk_last)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         second_q <= 1'b0;
         slot_q   <= '0;
         last_q   <= '0;
         rsp_v_q  <= 1'b0;
         rsp_e_q  <= 1'b0;
         f_q      <= '0;
         for (int i = 0; i < SLOTS; i++) cmds_q[i] <= C_HALF2;
      end else begin
         rsp_v_q <= 1'b0;
         if (accept) begin
            rsp_v_q <= 1'b1;
            rsp_e_q <= chk_err;
            if (!chk_err) begin
               busy_q   <= 1'b1;
               second_q <= 1'b0;
               slot_q   <= '0;
               last_q   <= chk_last;
               cmds_q   <= chk_cmds;
               f_q      <= req_f;
            end
         end else if (busy_q) begin
            if (second_q) begin
               second_q <= 1'b0;
               if (slot_q == last_q) busy_q <= 1'b0;
               else                  slot_q <= slot_q + 1'b1;
            end else begin
               second_q <= 1'b1;
            end
         end
      end
   end

   ca_beat_gen #(
      .OP_OPEN1(OP_OPEN1), .OP_OPEN2(OP_OPEN2), .OP_RD(OP_RD),
      .OP_WR(OP_WR), .OP_MRD(OP_MRD), .OP_HALF2(OP_HALF2)
   ) u_beat (
      .cmd    (cmds_q[slot_q]),
      .second (second_q),
      .f      (f_q),
      .ca     (beat_ca)
   );

   assign mem_cs    = busy_q && !second_q;
   assign mem_ca    = busy_q ? beat_ca : IDLE_CA;
   assign rsp_valid = rsp_v_q;
   assign rsp_err   = rsp_e_q;

   // R2: chip select marks only the first cycle of a command
   p_cs_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cs |=> !mem_cs);

   // R10: a refusal drives no command
   p_reject_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (!mem_cs && req_ready));

   // R11: no new request is taken while a command is on the bus
   p_ready_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cs |-> !req_ready);

   // R11: a response follows only an accepted request
   p_rsp_after_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid && req_ready));

   // R12: transfer commands are followed directly by the second-half command
   p_half_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_cs && (mem_ca[5:3] == OP_RD || mem_ca[5:3] == OP_WR || mem_ca[5:3] == OP_MRD))
      |=> ##1 (mem_cs && mem_ca[5:3] == OP_HALF2));

   // R5: an open prepended to a transfer always shows up as open-1 first
   p_open_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !chk_err && chk_need_open) |=> (mem_cs && mem_ca[5:3] == OP_OPEN1));
endmodule

// File: tb/ca_pair_sequencer_test.sv
module ca_pair_sequencer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [1:0]  req_kind = 2'b00;
   logic [2:0]  req_bank = '0;
   logic [14:0] req_row = '0;
   logic [9:0]  req_col = '0;
   logic        rsp_valid, rsp_err, mem_cs;
   logic [5:0]  mem_ca;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   bit          m_open [8];
   logic [14:0] m_row  [8];

   always #4 clk = ~clk;

   ca_pair_sequencer uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_kind(req_kind), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .mem_cs(mem_cs), .mem_ca(mem_ca)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // command ids: 0 open-1, 1 open-2, 2 read, 3 write, 4 mode-read, 5 second-half
   function automatic logic [5:0] enc(input int cmd, input int b, input logic [2:0] bank,
                                      input logic [14:0] row, input logic [9:0] col);
      case (cmd)
         0: return (b == 0) ? {3'd1, bank} : row[14:9];
         1: return (b == 0) ? {3'd2, row[8:6]} : row[5:0];
         2: return (b == 0) ? {3'd3, bank} : col[9:4];
         3: return (b == 0) ? {3'd4, bank} : col[9:4];
         4: return (b == 0) ? {3'd5, 3'd0} : row[5:0];
         default: return (b == 0) ? {3'd6, 3'd0} : {col[3:2], 4'b0000};
      endcase
   endfunction

   task automatic issue(input logic [1:0] kind, input logic [2:0] bank, input logic [14:0] row,
                        input logic [9:0] col, input string tag);
      int cmds[4];
      int n = 0;
      bit err = 0;
      case (kind)
         2'b00: if (m_open[bank]) err = 1;
                else begin cmds[0] = 0; cmds[1] = 1; n = 2; end
         2'b01, 2'b10: begin
            if ((kind == 2'b01) ? (col[1:0] != 0) : (col[3:0] != 0)) err = 1;
            else if (m_open[bank] && m_row[bank] != row) err = 1;
            else begin
               if (!m_open[bank]) begin cmds[0] = 0; cmds[1] = 1; n = 2; end
               cmds[n] = (kind == 2'b01) ? 2 : 3;
               cmds[n+1] = 5;
               n += 2;
            end
         end
         default: if (col != 0) err = 1;
                  else begin cmds[0] = 4; cmds[1] = 5; n = 2; end
      endcase

      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1; req_kind = kind; req_bank = bank; req_row = row; req_col = col;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(rsp_valid == 1'b1, {tag, " rsp_valid"}, rsp_valid, 1);
      chk(rsp_err == err, {tag, " rsp_err"}, rsp_err, err);
      if (err) begin
         chk(mem_cs == 1'b0 && mem_ca == 6'd0, {tag, " R10 bus quiet"}, {mem_cs, mem_ca}, 0);
         chk(req_ready == 1'b1, {tag, " R10 ready"}, req_ready, 1);
      end else begin
         for (int i = 0; i < 2 * n; i++) begin
            logic [5:0] e;
            if (i > 0) @(negedge clk);
            e = enc(cmds[i/2], i % 2, bank, row, col);
            chk(mem_cs == (i % 2 == 0), {tag, " R2 cs"}, mem_cs, (i % 2 == 0));
            chk(mem_ca == e, {tag, " R3 ca"}, mem_ca, e);
            chk(req_ready == 1'b0, {tag, " R11 ready low"}, req_ready, 0);
         end
         @(negedge clk);
         chk(mem_cs == 1'b0 && mem_ca == 6'd0 && req_ready == 1'b1,
             {tag, " R11 idle after"}, {req_ready, mem_cs, mem_ca}, 32'h80);
         if (kind == 2'b00 || ((kind == 2'b01 || kind == 2'b10) && !m_open[bank])) begin
            m_open[bank] = 1;
            m_row[bank] = row;
         end
      end
   endtask

   task automatic t_reset;
      chk(req_ready == 1 && mem_cs == 0 && mem_ca == 0 && rsp_valid == 0,
          "R1 reset state", {req_ready, mem_cs, rsp_valid, mem_ca}, 32'h100);
   endtask

   task automatic t_open;
      issue(2'b00, 3'd2, 15'h5A5A, 10'd0, "R4 open bank2");
      issue(2'b00, 3'd2, 15'h1111, 10'd0, "R4 reopen refused");
   endtask

   task automatic t_read_closed;
      issue(2'b01, 3'd5, 15'h6C3F, 10'h3F4, "R5 read closed bank5");
   endtask

   task automatic t_read_open;
      issue(2'b01, 3'd5, 15'h6C3F, 10'h10C, "R6 read hit");
      issue(2'b01, 3'd5, 15'h0001, 10'h100, "R6 read row miss");
   endtask

   task automatic t_align;
      issue(2'b01, 3'd6, 15'h0123, 10'h002, "R7 read misaligned");
      issue(2'b01, 3'd6, 15'h0123, 10'h001, "R7 read misaligned c0");
      issue(2'b10, 3'd2, 15'h5A5A, 10'h008, "R8 write misaligned");
      issue(2'b10, 3'd2, 15'h5A5A, 10'h3F0, "R8 write aligned hit");
      issue(2'b10, 3'd1, 15'h7FFF, 10'h2A0, "R8 R5 write closed");
      // bank6 still closed after refusals: expect full open sequence
      issue(2'b01, 3'd6, 15'h0123, 10'h004, "R10 state kept bank6");
   endtask

   task automatic t_mrd;
      issue(2'b11, 3'd7, 15'h002A, 10'h000, "R9 mode read");
      issue(2'b11, 3'd7, 15'h002A, 10'h004, "R9 mode read nonzero col");
      // bank7 untouched by mode read: expect full open sequence
      issue(2'b01, 3'd7, 15'h4321, 10'h008, "R9 R12 bank7 closed");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_open();
      t_read_closed();
      t_read_open();
      t_align();
      t_mrd();
      repeat (2) @(negedge clk);
      if (!done) begin
         done = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule